// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block holds several independent timer channels behind a small synchronous register port. Each channel owns a 32-bit counter that steps down by one on every tick of its chosen source. The source is either a shared external slow tick, a tick on every clock, or nothing at all. Software loads the counter directly, or through a separate reload register. It then picks one-shot behaviour, where the channel parks at zero, or periodic behaviour, where the channel refills from the reload register and keeps going.

On the step into zero the channel raises a sticky status bit. Each channel drives its own interrupt line, which is high while status and enable are both set. Every register has a plain write address and two more addresses four and eight bytes above it. The first of these ORs the written data in, and the second clears the bits written as one. A global register can freeze every channel at once, and a read-only word reports the major version.

Top module: `tick_timer_bank`

## Requirements
- R1: Reset clears every control field, both count registers, the freeze bit and every status flag, so all interrupt lines are low.
- R2: Byte addresses (word aligned, low two bits zero) decode as follows: channel n control at 0x20+0x40*n, running count at 0x30+0x40*n, reload value at 0x40+0x40*n, global register at 0x00, version at 0x10. A channel index at or above the channel count, or any other address, reads 0 and ignores writes.
- R3: The version word reads 0x0200_0000, with major version 2 in bits 31:24.
- R4: Control bits 3:0 pick the tick source. Value 0x0 halts the channel, 0xB follows the tick_ext input, and 0xF ticks on every clock. Each tick lowers a nonzero counter by exactly one.
- R5: With control bit 6 (periodic) clear, a counter at zero stays at zero.
- R6: With control bit 6 set, a tick that finds the counter at zero loads it from the reload register, which gives an event every reload+1 ticks.
- R7: With control bit 7 (immediate load) set, a write to the reload register also loads the running counter in the same cycle.
- R8: With control bit 7 clear, a reload-register write leaves the running counter untouched. A running-count write loads the counter in any mode.
- R9: Control bit 15 (status) sets when a tick moves the counter from 1 to 0. It stays set until software writes it to 0, and irq[n] is high while bit 15 and bit 14 (enable) are both set.
- R10: When a zero event and a software clear of bit 15 fall in the same cycle, the status stays set.
- R11: Writing to base+0x4 ORs the data into the register, and writing to base+0x8 clears the bits that are one in the data. Other bits are untouched. Reads at either alias return the register.
- R12: Global register bit 0, when set, stops all ticks on every channel.
- R13: rd_data shows the addressed register one cycle after rd_en, and is 0 after any cycle without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| tick_ext | input | 1 | External slow tick, one clock wide per tick |
| rd_data | output | 32 | Registered read data |
| irq | output | NCH | Interrupt per channel |

## Verification
The bench builds the block with its defaults: two channels, 32-bit counters and a 12-bit address. Two channels are enough to show that the per-channel stride decodes correctly, and that a read of a third, absent channel returns zero. Because the every-clock tick source is available, each count-down, reload and zero-event collision lands on a known edge within a few cycles. The bench can therefore check the interrupt line on the exact cycle it rises.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_NONE = 2'd3} reg_op_e;
  typedef enum logic [1:0] {RK_CTRL = 2'd0, RK_RUN = 2'd1, RK_FIX = 2'd2, RK_NONE = 2'd3} reg_kind_e;

  localparam int CB_PERIODIC = 6;
  localparam int CB_IMMED    = 7;
  localparam int CB_IE       = 14;
  localparam int CB_STAT     = 15;

  localparam logic [3:0] SRC_OFF = 4'h0;
  localparam logic [3:0] SRC_EXT = 4'hB;
  localparam logic [3:0] SRC_ALL = 4'hF;

  localparam logic [31:0] CH_BASE    = 32'h20;
  localparam logic [31:0] VER_ADDR   = 32'h10;
  localparam logic [31:0] VER_WORD   = 32'h0200_0000;

  function automatic logic [DATA_W-1:0] apply_op(reg_op_e op, logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] wd);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_glob,
  output logic              is_ver,
  output logic [NCH-1:0]    ch_hit,
  output reg_kind_e         kind,
  output reg_op_e           op
);
  localparam int IDX_W = ADDR_W - 6;

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    is_glob = 1'b0;
    is_ver  = 1'b0;
    ch_hit  = '0;
    kind    = RK_NONE;
    op      = OP_NONE;
    off     = addr - ADDR_W'(CH_BASE);
    idx     = off[ADDR_W-1:6];
    if (addr[1:0] == 2'b00) begin
      if (addr < ADDR_W'(CH_BASE)) begin
        if (!addr[4]) begin
          op      = reg_op_e'(addr[3:2]);
          is_glob = (addr[3:2] != 2'b11);
        end else if (addr[3:2] == 2'b00) begin
          is_ver = 1'b1;
        end
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (idx == IDX_W'(i)) ch_hit[i] = 1'b1;
        end
        kind = reg_kind_e'(off[5:4]);
        op   = reg_op_e'(off[3:2]);
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              tick_ext,
  input  logic              wr_ctrl,
  input  logic              wr_run,
  input  logic              wr_fix,
  input  reg_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] run_rd,
  output logic [DATA_W-1:0] fix_rd,
  output logic              tick_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              stat_o,
  output logic              periodic_o,
  output logic              irq_o
);
  logic [3:0]        src_q;
  logic              periodic_q, immed_q, ie_q, stat_q;
  logic [CNT_W-1:0]  cnt_q, fix_q;
  logic [DATA_W-1:0] ctrl_img, ctrl_new, run_new, fix_new;
  logic              tick, load_run, load_fix, zero_evt;
  logic              unused_bits;

  always_comb begin
    ctrl_img              = '0;
    ctrl_img[3:0]         = src_q;
    ctrl_img[CB_PERIODIC] = periodic_q;
    ctrl_img[CB_IMMED]    = immed_q;
    ctrl_img[CB_IE]       = ie_q;
    ctrl_img[CB_STAT]     = stat_q;
  end

  assign ctrl_new = apply_op(op, ctrl_img, wdata);
  assign run_new  = apply_op(op, DATA_W'(cnt_q), wdata);
  assign fix_new  = apply_op(op, DATA_W'(fix_q), wdata);
  assign unused_bits = ^{ctrl_new[31:16], ctrl_new[13:8], ctrl_new[5:4]};

  assign tick     = !freeze && (((src_q == SRC_EXT) && tick_ext) || (src_q == SRC_ALL));
  assign load_run = wr_run;
  assign load_fix = wr_fix && immed_q;
  assign zero_evt = tick && (cnt_q == CNT_W'(1)) && !load_run && !load_fix;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q      <= SRC_OFF;
      periodic_q <= 1'b0;
      immed_q    <= 1'b0;
      ie_q       <= 1'b0;
      stat_q     <= 1'b0;
      cnt_q      <= '0;
      fix_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        src_q      <= ctrl_new[3:0];
        periodic_q <= ctrl_new[CB_PERIODIC];
        immed_q    <= ctrl_new[CB_IMMED];
        ie_q       <= ctrl_new[CB_IE];
      end
      stat_q <= zero_evt | (wr_ctrl ? ctrl_new[CB_STAT] : stat_q);
      if (wr_fix) fix_q <= CNT_W'(fix_new);
      if (load_run) begin
        cnt_q <= CNT_W'(run_new);
      end else if (load_fix) begin
        cnt_q <= CNT_W'(fix_new);
      end else if (tick) begin
        if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
        else if (periodic_q) cnt_q <= fix_q;
      end
    end
  end

  assign ctrl_rd    = ctrl_img;
  assign run_rd     = DATA_W'(cnt_q);
  assign fix_rd     = DATA_W'(fix_q);
  assign tick_o     = tick;
  assign cnt_o      = cnt_q;
  assign stat_o     = stat_q;
  assign periodic_o = periodic_q;
  assign irq_o      = stat_q & ie_q;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              tick_ext,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq
);
  logic                          is_glob, is_ver;
  logic [NCH-1:0]                ch_hit;
  reg_kind_e                     kind;
  reg_op_e                       op;
  logic                          freeze_q;
  logic [NCH-1:0][DATA_W-1:0]    ctrl_rd, run_rd, fix_rd;
  logic [NCH-1:0][CNT_W-1:0]     ch_cnt;
  logic [NCH-1:0]                ch_tick, ch_stat, ch_periodic, ch_wr;
  logic [DATA_W-1:0]             rd_mux, rd_q;

  tmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .is_glob(is_glob), .is_ver(is_ver),
    .ch_hit(ch_hit), .kind(kind), .op(op)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_ok;
    assign sel_ok   = wr_en && ch_hit[g] && (op != OP_NONE);
    assign ch_wr[g] = sel_ok && (kind != RK_NONE);
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .freeze(freeze_q), .tick_ext(tick_ext),
      .wr_ctrl(sel_ok && (kind == RK_CTRL)),
      .wr_run(sel_ok && (kind == RK_RUN)),
      .wr_fix(sel_ok && (kind == RK_FIX)),
      .op(op), .wdata(wr_data),
      .ctrl_rd(ctrl_rd[g]), .run_rd(run_rd[g]), .fix_rd(fix_rd[g]),
      .tick_o(ch_tick[g]), .cnt_o(ch_cnt[g]), .stat_o(ch_stat[g]),
      .periodic_o(ch_periodic[g]), .irq_o(irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_q <= 1'b0;
    end else if (wr_en && is_glob) begin
      case (op)
        OP_WR:   freeze_q <= wr_data[0];
        OP_SET:  freeze_q <= freeze_q | wr_data[0];
        OP_CLR:  freeze_q <= freeze_q & ~wr_data[0];
        default: freeze_q <= freeze_q;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_glob) rd_mux = DATA_W'(freeze_q);
    if (is_ver)  rd_mux = VER_WORD;
    if (op != OP_NONE) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit[i]) begin
          case (kind)
            RK_CTRL: rd_mux = ctrl_rd[i];
            RK_RUN:  rd_mux = run_rd[i];
            RK_FIX:  rd_mux = fix_rd[i];
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
    else            rd_q <= '0;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0]            ch_tick,
  input logic [NCH-1:0]            ch_stat,
  input logic [NCH-1:0]            ch_periodic,
  input logic [NCH-1:0]            ch_wr
);
  // R13: no read strobe, read data returns to zero
  p_rd_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  // R3: version word carries major version 2
  p_version_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(VER_ADDR))) |=> (rd_data[31:24] == 8'd2));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4: without a tick or a write the count holds
    p_halt_r4: assert property (@(posedge clk) disable iff (rst)
      (!ch_tick[g] && !ch_wr[g]) |=> $stable(ch_cnt[g]));

    // R4: a tick lowers a nonzero count by one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_tick[g] && !ch_wr[g] && (ch_cnt[g] != '0))
        |=> ((ch_cnt[g] + CNT_W'(1)) == $past(ch_cnt[g])));

    // R5: one-shot channel parks at zero
    p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
      ((ch_cnt[g] == '0) && !ch_periodic[g] && !ch_wr[g]) |=> (ch_cnt[g] == '0));

    // R10: the step into zero always leaves status set
    p_event_r10: assert property (@(posedge clk) disable iff (rst)
      (ch_tick[g] && (ch_cnt[g] == CNT_W'(1)) && !ch_wr[g]) |=> ch_stat[g]);

    // R9: status is sticky while software leaves the channel alone
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (ch_stat[g] && !ch_wr[g]) |=> ch_stat[g]);
  end
endmodule

bind tick_timer_bank tmr_checker #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tmr_checker (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rd_data(rd_data),
  .ch_cnt(ch_cnt), .ch_tick(ch_tick), .ch_stat(ch_stat),
  .ch_periodic(ch_periodic), .ch_wr(ch_wr)
);

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;
  localparam int NCH    = 2;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic              tick_ext = 1'b0;
  logic [31:0]       rd_data;
  logic [NCH-1:0]    irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tick_timer_bank #(.NCH(NCH), .CNT_W(32), .ADDR_W(ADDR_W)) u_tick_timer_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .tick_ext(tick_ext), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [ADDR_W-1:0] a_ctrl(int n); return ADDR_W'(32'h20 + n * 32'h40); endfunction
  function automatic logic [ADDR_W-1:0] a_run(int n);  return ADDR_W'(32'h30 + n * 32'h40); endfunction
  function automatic logic [ADDR_W-1:0] a_fix(int n);  return ADDR_W'(32'h40 + n * 32'h40); endfunction
  localparam logic [ADDR_W-1:0] A_GLOB = 12'h000;
  localparam logic [ADDR_W-1:0] A_VER  = 12'h010;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'h0);
    rd(a_ctrl(0), d); check("R1 ctrl0", d, 32'h0);
    rd(a_run(1), d);  check("R1 run1", d, 32'h0);
    rd(a_fix(1), d);  check("R1 fix1", d, 32'h0);
    rd(A_GLOB, d);    check("R1 global", d, 32'h0);
    rd(A_VER, d);     check("R3 version", d, 32'h0200_0000);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(a_run(0), 32'd5);
    wr(a_ctrl(0), 32'h0000_400F);
    repeat (4) @(posedge clk); #1;
    check("R4 irq before zero", 32'(irq[0]), 32'h0);
    @(posedge clk); #1;
    check("R9 irq at zero", 32'(irq[0]), 32'h1);
    rd(a_run(0), d); check("R5 parked", d, 32'h0);
    repeat (5) @(posedge clk); #1;
    rd(a_run(0), d); check("R5 still parked", d, 32'h0);
    wr(a_ctrl(0), 32'h0000_400F);
    check("R9 software clear", 32'(irq[0]), 32'h0);
    rd(a_ctrl(0), d); check("R9 ctrl after clear", d, 32'h0000_400F);
    wr(a_ctrl(0), 32'h0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(a_fix(1), 32'd2);
    rd(a_run(1), d); check("R8 no load without bit 7", d, 32'h0);
    wr(a_ctrl(1), 32'h0000_404F);
    repeat (2) @(posedge clk); #1;
    check("R6 irq before event", 32'(irq[1]), 32'h0);
    @(posedge clk); #1;
    check("R6 event after fix+1 ticks", 32'(irq[1]), 32'h1);
    wr(A_GLOB, 32'h1);
    rd(a_run(1), d); check("R6 refilled from reload", d, 32'd2);
    repeat (4) @(posedge clk); #1;
    rd(a_run(1), d); check("R12 frozen count", d, 32'd2);
    check("R9 sticky status", 32'(irq[1]), 32'h1);
    wr(a_ctrl(1) + 12'h8, 32'h0000_8000);
    check("R11 clear alias on status", 32'(irq[1]), 32'h0);
    rd(a_ctrl(1) + 12'h4, d); check("R11 other bits kept", d, 32'h0000_404F);
    rd(a_fix(0), d); check("R2 channel 0 reload separate", d, 32'h0);
    wr(a_ctrl(1), 32'h0);
    wr(A_GLOB, 32'h0);
  endtask

  task automatic t_update();
    logic [31:0] d;
    wr(a_ctrl(0), 32'h0000_0080);
    wr(a_fix(0), 32'h0000_1234);
    rd(a_run(0), d); check("R7 immediate load", d, 32'h0000_1234);
    wr(a_ctrl(0), 32'h0);
    wr(a_fix(0), 32'h0000_0055);
    rd(a_run(0), d); check("R8 running untouched", d, 32'h0000_1234);
    rd(a_fix(0), d); check("R8 reload stored", d, 32'h0000_0055);
    repeat (5) @(posedge clk); #1;
    rd(a_run(0), d); check("R4 source 0 halts", d, 32'h0000_1234);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(a_ctrl(0) + 12'h4, 32'h0000_4000);
    rd(a_ctrl(0), d); check("R11 set alias ctrl", d, 32'h0000_4000);
    wr(a_run(0) + 12'h4, 32'h0001_0000);
    rd(a_run(0), d); check("R11 set alias run", d, 32'h0001_1234);
    wr(a_run(0) + 12'h8, 32'h0000_1004);
    rd(a_run(0) + 12'h8, d); check("R11 clear alias run", d, 32'h0001_0230);
    wr(a_ctrl(0) + 12'h8, 32'h0000_4000);
    rd(a_ctrl(0), d); check("R11 clear alias ctrl", d, 32'h0);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    wr(a_run(0), 32'd3);
    wr(a_ctrl(0), 32'h0000_400B);
    repeat (5) @(posedge clk); #1;
    rd(a_run(0), d); check("R4 no external tick", d, 32'd3);
    for (int k = 0; k < 3; k++) begin
      if (k == 2) check("R4 irq after two ext ticks", 32'(irq[0]), 32'h0);
      tick_ext = 1'b1;
      @(posedge clk); #1;
      tick_ext = 1'b0;
      @(posedge clk); #1;
    end
    check("R4 irq after three ext ticks", 32'(irq[0]), 32'h1);
    rd(a_run(0), d); check("R4 ext count at zero", d, 32'h0);
  endtask

  task automatic t_collide();
    wr(a_run(0), 32'd2);
    wr(a_ctrl(0), 32'h0000_400F);
    check("R9 cleared by write of 0", 32'(irq[0]), 32'h0);
    @(posedge clk); #1;
    wr(a_ctrl(0) + 12'h8, 32'h0000_8000);
    check("R10 zero beats clear", 32'(irq[0]), 32'h1);
    wr(a_ctrl(0) + 12'h8, 32'h0000_8000);
    check("R9 later clear works", 32'(irq[0]), 32'h0);
    wr(a_ctrl(0), 32'h0);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    check("R13 idle read data", rd_data, 32'h0);
    wr(a_ctrl(2), 32'hFFFF_FFFF);
    rd(a_ctrl(2), d); check("R2 absent channel", d, 32'h0);
    rd(12'h00C, d);   check("R2 unmapped word", d, 32'h0);
    check("R2 absent write no irq", 32'(irq), 32'h0);
    @(posedge clk); #1;
    check("R13 zero after read", rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    t_reset();
    t_oneshot();
    t_reload();
    t_update();
    t_alias();
    t_ext();
    t_collide();
    t_misc();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule